// File: doc/BRIEF.md
# Supply Reset Pulse Stretcher

This block turns two asynchronous reset causes into a clean processor reset. One cause is a digitised flag that is high while the supply sits below its trip level. The other is a manual request that is active low, coming from a push button, from another logic output, or from a watchdog output that has been wired back into it. Both causes are brought into the clock domain through two-flop synchronisers. Reset is then driven as a complementary pair: one active-low output and one active-high output.

While either synchronised cause is present, a hold counter is kept at zero. Once every cause has gone away, the counter runs up to `HOLD_CYCLES` (about 200 ms of system clock in silicon, a small value in simulation), and reset is released only when it gets there. Any new cause arriving during the hold sends the counter back to zero, so a full period starts again. This hold window is the only debounce the manual input receives. The block takes no watchdog input: a watchdog timeout resets the processor only if it is routed externally into the manual request. After the asynchronous power-on initialisation, reset starts asserted and runs one full hold period before it is released for the first time.

Top module: `supply_reset_stretcher`

## Requirements
- R1: While `por_n` is low, `rst_o` is 1 and `rst_n_o` is 0. With both causes idle after `por_n` rises, reset stays asserted through the first `HOLD_CYCLES-1` rising edges and is released at edge number `HOLD_CYCLES`.
- R2: `supply_low_i`=1 is a reset cause. If it is sampled high at rising edge j while reset is released, reset is asserted from edge j+2 onward (two synchroniser stages).
- R3: Reset stays asserted for as long as `supply_low_i` keeps being sampled high.
- R4: If edge j is the last edge at which any cause was sampled, reset is released exactly at edge j+2+`HOLD_CYCLES` and not before.
- R5: A cause sampled during an active hold restarts the hold from zero, so the release moves to a full `HOLD_CYCLES` after the synchronised new cause.
- R6: `manual_req_n_i` is active low. A 0 is a reset cause with the same latency and hold as in R2 to R4, and a 1 has no effect.
- R7: Chatter on the manual input is not filtered beyond the hold. A single-cycle low pulse produces a full hold, and every low sample during the hold restarts it.
- R8: `rst_o` is the exact complement of `rst_n_o` in every cycle, including during power-on initialisation.
- R9: Once released with both causes idle, reset stays released indefinitely: the hold counter saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| supply_low_i | input | 1 | Asynchronous supply-below-threshold flag, active high |
| manual_req_n_i | input | 1 | Asynchronous manual reset request, active low |
| rst_n_o | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high, complement of `rst_n_o` |

## Verification
The bench targets the exact release edge. A design that counts one cycle too many or too few, or that drops a synchroniser stage, moves the falling edge of `rst_o` and fails on that cycle. Single-cycle pulses and second events placed mid-hold catch a counter that only pauses instead of restarting, or that ignores short pulses. A chattering manual input catches any hidden extra debounce. Long idle stretches after release expose a counter that wraps and re-asserts reset. The output pair is compared in every cycle, so a polarity stage with a wrong reset value or a lag on one output shows up at once.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;
  typedef enum int unsigned {
    SRC_SUPPLY = 0,
    SRC_MANUAL = 1
  } cause_src_e;

  localparam int unsigned NUM_SRC = 2;

  // Idle (no-cause) level for each raw input, indexed by cause_src_e
  localparam logic [NUM_SRC-1:0] SRC_IDLE = 2'b10;
endpackage

// File: rtl/cause_sync.sv
module cause_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain_q[b] <= {STAGES{IDLE[b]}};
      else        chain_q[b] <= {chain_q[b][STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_CYCLES = 20_000_000,
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic cause_i,
  output logic active_next_o
);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cause_i)             cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_next_o = (cnt_d != LIMIT);

  // R5: a synchronised cause forces the count back to zero
  p_restart_r5: assert property (@(posedge clk) disable iff (!por_n)
    cause_i |=> (cnt_q == '0));

  // R4: with no cause, the count advances by exactly one until the limit
  p_step_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!cause_i && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R9: the count saturates at the limit while idle
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!cause_i && cnt_q == LIMIT) |=> (cnt_q == LIMIT));
endmodule

// File: rtl/reset_pair.sv
module reset_pair (
  input  logic clk,
  input  logic por_n,
  input  logic active_next_i,
  output logic rst_n_o,
  output logic rst_o
);
  logic low_q, high_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      low_q  <= 1'b0;
      high_q <= 1'b1;
    end else begin
      low_q  <= ~active_next_i;
      high_q <= active_next_i;
    end
  end

  assign rst_n_o = low_q;
  assign rst_o   = high_q;

  // R8: the two separately registered polarities never disagree
  p_complement_r8: assert property (@(posedge clk) disable iff (!por_n)
    rst_o == ~rst_n_o);
endmodule

// File: rtl/supply_reset_stretcher.sv
module supply_reset_stretcher
  import rst_stretch_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 20_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low_i,
  input  logic manual_req_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  logic [NUM_SRC-1:0] raw, synced;
  logic cause_s, active_next;

  assign raw[SRC_SUPPLY] = supply_low_i;
  assign raw[SRC_MANUAL] = manual_req_n_i;

  cause_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES), .IDLE(SRC_IDLE)) u_sync (
    .clk(clk), .por_n(por_n), .async_i(raw), .sync_o(synced)
  );

  // R6: manual request is active low, supply flag active high
  assign cause_s = synced[SRC_SUPPLY] | ~synced[SRC_MANUAL];

  hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .por_n(por_n), .cause_i(cause_s), .active_next_o(active_next)
  );

  reset_pair u_pair (
    .clk(clk), .por_n(por_n), .active_next_i(active_next),
    .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  // R2: a synchronised cause always yields an asserted reset next cycle
  p_cause_asserts_r2: assert property (@(posedge clk) disable iff (!por_n)
    cause_s |=> rst_o);

  // R4: release only happens when no cause was present the cycle before
  p_release_clean_r4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_o) |-> !$past(cause_s));

  // R3: reset never drops while the synchronised supply flag is high
  p_hold_supply_r3: assert property (@(posedge clk) disable iff (!por_n)
    (synced[SRC_SUPPLY] && $past(synced[SRC_SUPPLY])) |-> rst_o);
endmodule

// File: tb/test_supply_reset_stretcher.sv
module test_supply_reset_stretcher;
  localparam int unsigned HOLD = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_low = 1'b0;
  logic manual_n = 1'b1;
  logic rst_n_o, rst_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  supply_reset_stretcher #(.HOLD_CYCLES(HOLD)) i_supply_reset_stretcher (
    .clk(clk), .por_n(por_n), .supply_low_i(supply_low),
    .manual_req_n_i(manual_n), .rst_n_o(rst_n_o), .rst_o(rst_o)
  );

  // Expected-value model from the latency rules: a cause sampled at edge j
  // zeroes the elapsed count at edge j+2; release once HOLD edges have elapsed.
  logic seen1 = 1'b0, seen2 = 1'b0;
  int unsigned elapsed = 0;

  function automatic logic cause_of(logic s, logic m_n);
    return s | ~m_n;
  endfunction

  function automatic logic expect_rst(int unsigned el);
    return el < HOLD;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      seen1 <= 1'b0; seen2 <= 1'b0; elapsed <= 0;
    end else begin
      cycles <= cycles + 1;
      seen1 <= cause_of(supply_low, manual_n);
      seen2 <= seen1;
      if (seen2) elapsed <= 0;
      else if (elapsed < HOLD) elapsed <= elapsed + 1;
    end
  end

  task automatic check(string tag);
    logic e;
    e = por_n ? expect_rst(elapsed) : 1'b1;
    checks++;
    if (rst_o !== e) begin
      errors++;
      $display("FAIL %s: rst_o=%b expected %b (cycle %0d)", tag, rst_o, e, cycles);
    end
    checks++;
    if (rst_n_o !== ~rst_o) begin
      errors++;
      $display("FAIL R8: rst_n_o=%b expected %b", rst_n_o, ~rst_o);
    end
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    // R1: reset state during power-on initialisation
    run(3, "R1");
    @(negedge clk); por_n = 1'b1;
    // R1: exact first release after one hold period
    run(HOLD + 4, "R1");
    // R9: stays released while idle, well past the counter limit
    run(3 * HOLD, "R9");
    // R2/R3: supply low for several cycles
    supply_low = 1'b1;
    run(6, "R2");
    run(6, "R3");
    supply_low = 1'b0;
    run(HOLD + 4, "R4");
    // R5: single-cycle pulse, then a second pulse mid-hold
    supply_low = 1'b1; run(1, "R5"); supply_low = 1'b0;
    run(HOLD / 2, "R5");
    supply_low = 1'b1; run(1, "R5"); supply_low = 1'b0;
    run(HOLD + 4, "R5");
    // R6: manual request active low; high level is no cause
    manual_n = 1'b0; run(4, "R6"); manual_n = 1'b1;
    run(HOLD + 8, "R6");
    // R7: single-cycle manual glitch gives a full hold
    manual_n = 1'b0; run(1, "R7"); manual_n = 1'b1;
    run(HOLD + 4, "R7");
    // R7: chatter keeps restarting the hold
    for (int k = 0; k < 8; k++) begin
      manual_n = ~manual_n;
      run(3, "R7");
    end
    manual_n = 1'b1;
    run(HOLD + 4, "R7");
    // R4/R5: constrained random mix of both causes
    for (int k = 0; k < 3000; k++) begin
      supply_low = ($urandom % 40) == 0;
      manual_n   = ($urandom % 50) != 0;
      if (($urandom % 200) == 0) begin
        supply_low = 1'b0; manual_n = 1'b1;
        run(HOLD + 3, "R4");
      end else begin
        run(1, "R5");
      end
    end
    supply_low = 1'b0; manual_n = 1'b1;
    run(HOLD + 6, "R9");
    finish_run();
  end
endmodule